// File: doc/BRIEF.md
# FIFO read-strobe handshake controller

This block sits on the consumer side of an asynchronous-style strobe FIFO, one that signals "output word valid" on a ready flag and advances when it is pulsed with a shift-out strobe. The controller raises the shift-out strobe only while the FIFO reports a valid word. It keeps the strobe high until the FIFO withdraws its ready flag in response, so every strobe is long enough to be seen. The output word is registered on the strobe's leading edge, when the bus is known to be stable, and the register is announced with a one-cycle valid pulse.

A FIFO that has just gone from empty to holding one word has a short window in which a shift-out strobe may be lost. The controller therefore counts the words it has seen written (shift-in rising edges accepted while the input-ready flag is high) and the words it has removed. When that count shows the FIFO empty, the first shift-out after the ready flag comes back is held off by a fixed number of clock cycles. Later words go out without delay. As a build option, reading can instead begin only once an occupancy input reports more than half the depth. Several FIFOs placed side by side for a wider word are handled by ANDing their ready flags into composite flags. All inputs are taken as synchronous to `clk`, and cycle counts stand in for analog delays.

States: IDLE (FIFO tracked as empty), WAIT_GUARD (guard count running), SO_HIGH (strobe high, waiting for the ready flag to drop) and SO_LOW (strobe low, FIFO not empty). The transitions are:
- IDLE→WAIT_GUARD when composite ready is seen.
- WAIT_GUARD→SO_HIGH when the guard has expired, ready and request are high and the start gate is open.
- SO_LOW→SO_HIGH when ready, request and the start gate are all high.
- SO_HIGH→SO_LOW when ready drops and words remain.
- SO_HIGH→IDLE when ready drops and the tracked count reaches zero.

Top module: `rd_strobe_ctrl`

## Requirements
- R1: While `rst_n` is low and on release, `fifo_so_o` is 0, `word_vld_o` is 0, `word_o` is all zeros and the controller is in IDLE.
- R2: `fifo_so_o` rises only at a clock edge where the composite ready (AND of all bits of `fifo_or_i`) is sampled high.
- R3: Once high, `fifo_so_o` stays high while composite ready is sampled high, and goes low at the first edge where composite ready is sampled low.
- R4: At the edge where `fifo_so_o` rises, `word_o` loads the value of `fifo_dout_i` sampled at that edge and `word_vld_o` is high for exactly that one cycle; each FIFO word is delivered once and in write order.
- R5: When the FIFO is tracked as empty, the first strobe is raised GUARD_CYC edges after the edge at which composite ready is first sampled high.
- R6: When the FIFO is not tracked as empty, the strobe rises at the same edge at which composite ready and the request are sampled high, with no guard delay.
- R7: `fifo_so_o` never rises at an edge where `take_req_i` is sampled low.
- R8: With HALF_START=1, `fifo_so_o` rises only at an edge where `fill_level_i` is sampled greater than DEPTH/2.
- R9: `space_all_o` is the AND of all bits of `fifo_ir_i`.
- R10: A write is counted on a rising edge of `fifo_si_i` while `space_all_o` is high, and a removal is counted when the strobe falls. A removal that leaves the count at zero returns the controller to IDLE, so the guard of R5 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_or_i | input | N_BANKS | Per-FIFO output-ready flags |
| fifo_ir_i | input | N_BANKS | Per-FIFO input-ready flags |
| fifo_si_i | input | 1 | Observed shift-in strobe from the producer |
| fifo_dout_i | input | DATA_W*N_BANKS | Concatenated FIFO output data |
| fill_level_i | input | clog2(DEPTH+1) | Occupancy, used for the half-full start gate |
| take_req_i | input | 1 | Consumer request to take a word |
| fifo_so_o | output | 1 | Shift-out strobe to all FIFOs |
| word_o | output | DATA_W*N_BANKS | Captured word |
| word_vld_o | output | 1 | One-cycle pulse with each captured word |
| space_all_o | output | 1 | Composite input-ready flag |

## Verification
The main instance is built with two 4-bit banks, a depth of 8 and a guard of 3 cycles. The second bank's flags trail the first by one cycle, so the composite AND is what governs both the strobe and the write counting. A shallow depth lets bursty random traffic drain the FIFO many times, so the guard, the return to IDLE and the back-to-back unguarded strobes all recur through a 300-word stream. A second instance is built with HALF_START=1 and a guard of 1. It is driven directly to show that the strobe waits for the occupancy to pass half of the depth.

// File: rtl/rdsc_pkg.sv
package rdsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_GUARD = 2'd1,
        ST_SO_HIGH    = 2'd2,
        ST_SO_LOW     = 2'd3
    } rd_state_t;

endpackage

// File: rtl/rdsc_flag_merge.sv
module rdsc_flag_merge #(
    parameter int N_BANKS = 1
) (
    input  logic [N_BANKS-1:0] or_i,
    input  logic [N_BANKS-1:0] ir_i,
    output logic               rdy_all_o,
    output logic               space_all_o
);

    generate
        if (N_BANKS == 1) begin : g_single
            assign rdy_all_o   = or_i[0];
            assign space_all_o = ir_i[0];
        end else begin : g_multi
            assign rdy_all_o   = &or_i;
            assign space_all_o = &ir_i;
        end
    endgenerate

endmodule

// File: rtl/rdsc_fill_track.sv
module rdsc_fill_track #(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             si_i,
    input  logic             space_i,
    input  logic             pop_i,
    output logic [LVL_W-1:0] level_o,
    output logic             wr_evt_o
);

    logic             si_q;
    logic [LVL_W-1:0] level_q;
    logic             can_pop;

    assign wr_evt_o = si_i && !si_q && space_i && (level_q < LVL_W'(DEPTH));
    assign can_pop  = pop_i && (level_q != '0);
    assign level_o  = level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            si_q    <= 1'b0;
            level_q <= '0;
        end else begin
            si_q <= si_i;
            unique case ({wr_evt_o, can_pop})
                2'b10:   level_q <= level_q + LVL_W'(1);
                2'b01:   level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

endmodule

// File: rtl/rd_strobe_ctrl.sv
module rd_strobe_ctrl
    import rdsc_pkg::*;
#(
    parameter int DATA_W     = 4,
    parameter int N_BANKS    = 1,
    parameter int DEPTH      = 64,
    parameter int GUARD_CYC  = 2,
    parameter int HALF_START = 0,
    localparam int BUS_W     = DATA_W * N_BANKS,
    localparam int LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_BANKS-1:0] fifo_or_i,
    input  logic [N_BANKS-1:0] fifo_ir_i,
    input  logic               fifo_si_i,
    input  logic [BUS_W-1:0]   fifo_dout_i,
    input  logic [LVL_W-1:0]   fill_level_i,
    input  logic               take_req_i,
    output logic               fifo_so_o,
    output logic [BUS_W-1:0]   word_o,
    output logic               word_vld_o,
    output logic               space_all_o
);

    // Guard counter must hold GUARD_CYC (at least 1).
    localparam int               GW        = $clog2(GUARD_CYC + 1);
    localparam logic [GW-1:0]    GUARD_LD  = GW'(GUARD_CYC);
    localparam int               HALF_MARK = DEPTH / 2;

    logic             rdy_all;
    logic             space_all;
    logic             wr_evt;
    logic             pop;
    logic             drained;
    logic             half_ok;
    logic             launch;
    logic [LVL_W-1:0] level;

    rd_state_t        state_q, state_d;
    logic [GW-1:0]    guard_q, guard_d;
    logic [BUS_W-1:0] word_q;
    logic             vld_q;

    rdsc_flag_merge #(
        .N_BANKS (N_BANKS)
    ) u_merge (
        .or_i        (fifo_or_i),
        .ir_i        (fifo_ir_i),
        .rdy_all_o   (rdy_all),
        .space_all_o (space_all)
    );

    // Strobe falls this edge: one word leaves the FIFO.
    assign pop = (state_q == ST_SO_HIGH) && !rdy_all;

    rdsc_fill_track #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .si_i     (fifo_si_i),
        .space_i  (space_all),
        .pop_i    (pop),
        .level_o  (level),
        .wr_evt_o (wr_evt)
    );

    // The word now leaving was the last one, and none arrives alongside.
    assign drained = (level == LVL_W'(1)) && !wr_evt;
    assign half_ok = (HALF_START == 0) || (fill_level_i > LVL_W'(HALF_MARK));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        guard_d = guard_q;
        launch  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rdy_all) begin
                    state_d = ST_WAIT_GUARD;
                    guard_d = GUARD_LD;
                end
            end
            ST_WAIT_GUARD: begin
                if (guard_q > GW'(1)) begin
                    guard_d = guard_q - GW'(1);
                end else if (rdy_all && take_req_i && half_ok) begin
                    launch  = 1'b1;
                    state_d = ST_SO_HIGH;
                end
            end
            ST_SO_HIGH: begin
                if (!rdy_all) begin
                    state_d = drained ? ST_IDLE : ST_SO_LOW;
                end
            end
            ST_SO_LOW: begin
                if (rdy_all && take_req_i && half_ok) begin
                    launch  = 1'b1;
                    state_d = ST_SO_HIGH;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            guard_q <= '0;
        end else begin
            state_q <= state_d;
            guard_q <= guard_d;
        end
    end

    // Capture on the strobe's leading edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= launch;
            if (launch) begin
                word_q <= fifo_dout_i;
            end
        end
    end

    // Outputs
    always_comb begin
        fifo_so_o   = (state_q == ST_SO_HIGH);
        word_o      = word_q;
        word_vld_o  = vld_q;
        space_all_o = space_all;
    end

endmodule

// File: rtl/rd_strobe_ctrl_chk.sv
module rd_strobe_ctrl_chk #(
    parameter int N_BANKS    = 1,
    parameter int LVL_W      = 7,
    parameter int HALF_START = 0,
    parameter int HALF_MARK  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_BANKS-1:0] fifo_or,
    input logic               take_req,
    input logic [LVL_W-1:0]   fill_level,
    input logic               fifo_so,
    input logic               word_vld
);

    AST_SO_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_so) |-> $past(&fifo_or)); // R2

    AST_SO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_so && (&fifo_or)) |=> fifo_so); // R3

    AST_SO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_so && !(&fifo_or)) |=> !fifo_so); // R3

    AST_VLD_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $rose(fifo_so)); // R4

    AST_RISE_GIVES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_so) |-> word_vld); // R4

    AST_NO_UNREQUESTED_SO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_so) |-> $past(take_req)); // R7

    AST_HALF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((HALF_START != 0) && $rose(fifo_so)) |-> ($past(fill_level) > LVL_W'(HALF_MARK))); // R8

endmodule

bind rd_strobe_ctrl rd_strobe_ctrl_chk #(
    .N_BANKS    (N_BANKS),
    .LVL_W      ($clog2(DEPTH + 1)),
    .HALF_START (HALF_START),
    .HALF_MARK  (DEPTH / 2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_or    (fifo_or_i),
    .take_req   (take_req_i),
    .fill_level (fill_level_i),
    .fifo_so    (fifo_so_o),
    .word_vld   (word_vld_o)
);

// File: tb/rd_strobe_ctrl_test.sv
`timescale 1ns/1ps
module rd_strobe_ctrl_test;

    localparam int DW    = 4;
    localparam int NB    = 2;
    localparam int DEP   = 8;
    localparam int GUARD = 3;
    localparam int LW    = $clog2(DEP + 1);
    localparam int NWORD = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // main instance signals
    logic [NB-1:0]    f_or = '0;
    logic [NB-1:0]    f_ir = '1;
    logic             f_si = 1'b0;
    logic [DW*NB-1:0] f_dout = '0;
    logic [LW-1:0]    f_fill = '0;
    logic             take_req = 1'b0;
    logic             fifo_so;
    logic [DW*NB-1:0] word;
    logic             word_vld;
    logic             space_all;

    // half-start instance signals
    logic          h_or = 1'b0;
    logic          h_req = 1'b0;
    logic [3:0]    h_dout = 4'hA;
    logic [LW-1:0] h_fill = '0;
    logic          h_so;
    logic [3:0]    h_word;
    logic          h_vld;
    logic          h_space;

    rd_strobe_ctrl #(.DATA_W(DW), .N_BANKS(NB), .DEPTH(DEP), .GUARD_CYC(GUARD), .HALF_START(0)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_or_i(f_or), .fifo_ir_i(f_ir), .fifo_si_i(f_si),
        .fifo_dout_i(f_dout), .fill_level_i(f_fill), .take_req_i(take_req),
        .fifo_so_o(fifo_so), .word_o(word), .word_vld_o(word_vld), .space_all_o(space_all));

    rd_strobe_ctrl #(.DATA_W(4), .N_BANKS(1), .DEPTH(DEP), .GUARD_CYC(1), .HALF_START(1)) uut_half (
        .clk(clk), .rst_n(rst_n), .fifo_or_i(h_or), .fifo_ir_i(1'b1), .fifo_si_i(1'b0),
        .fifo_dout_i(h_dout), .fill_level_i(h_fill), .take_req_i(h_req),
        .fifo_so_o(h_so), .word_o(h_word), .word_vld_o(h_vld), .space_all_o(h_space));

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // ---------------- behavioural strobe FIFO + producer state ----------------
    logic [7:0] q[$];
    logic [7:0] exp_q[$];
    bit   or_r = 0, or_prev = 0, ir_r = 1, ir_prev = 1, si_r = 0, so_prev_f = 0;
    int   cyc = 0;
    int   sent = 0, to_send = 0, delivered = 0;
    int   phase = 0;
    int   req_mode = 0;
    bit   comp_prev = 0;
    int   or_rise_cyc = 0;
    int   diffs[3];
    int   n_diff = 0;

    // ---------------- reference model of the controller ----------------
    bit        m_so = 0, m_vld = 0, m_empty = 1, m_si_prev = 0;
    logic [7:0] m_word = '0;
    int        m_wait = 0, m_level = 0;

    always @(posedge clk) begin
        bit rdy, wr, fire;
        if (!rst_n) begin
            m_so = 0; m_vld = 0; m_word = '0; m_empty = 1; m_wait = 0;
            m_level = 0; m_si_prev = 0;
        end else begin
            rdy  = &f_or;
            wr   = f_si && !m_si_prev && (&f_ir);
            fire = 0;
            if (m_so) begin
                if (!rdy) begin
                    m_so = 0;
                    if (m_level - 1 + int'(wr) == 0) begin
                        m_empty = 1;
                        m_wait  = 0;
                    end
                    if (m_level > 0) m_level = m_level - 1;
                end
            end else if (m_empty) begin
                if (m_wait == 0) begin
                    if (rdy) m_wait = 1;
                end else if (m_wait < GUARD) begin
                    m_wait = m_wait + 1;
                end else if (rdy && take_req) begin
                    fire = 1;
                    m_empty = 0;
                    m_wait = 0;
                end
            end else if (rdy && take_req) begin
                fire = 1;
            end
            m_vld = fire;
            if (fire) begin
                m_so   = 1;
                m_word = f_dout;
            end
            if (wr) m_level = m_level + 1;
            m_si_prev = f_si;
        end
    end

    // ---------------- per-cycle compare and FIFO update ----------------
    always @(negedge clk) begin
        bit comp;
        logic [7:0] w;
        cyc++;
        if (rst_n) begin
            chk(fifo_so === m_so, "R2/R3 strobe level", fifo_so, m_so);
            chk(word_vld === m_vld, "R4 valid pulse", word_vld, m_vld);
            chk(word === m_word, "R4 captured word", word, m_word);
            chk(space_all === (&f_ir), "R9 composite input ready", space_all, &f_ir);
            if (word_vld) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R4 word with nothing expected", word, 0);
                end else begin
                    w = exp_q.pop_front();
                    chk(word == w, "R4 stream order", word, w);
                end
                delivered++;
            end
            comp = &f_or;
            if (comp && !comp_prev) or_rise_cyc = cyc;
            if (fifo_so && !so_prev_f) begin
                chk(take_req == 1'b1, "R7 strobe raised without request", 0, 1);
                if (phase == 1 && n_diff < 3) begin
                    diffs[n_diff] = cyc - or_rise_cyc;
                    n_diff++;
                end
            end
            comp_prev = comp;
        end

        if (!rst_n) begin
            q.delete(); exp_q.delete();
            or_r = 0; or_prev = 0; ir_r = 1; ir_prev = 1; si_r = 0; so_prev_f = 0;
            comp_prev = 0;
            f_or = '0; f_ir = '1; f_si = 0; f_dout = '0; f_fill = '0;
        end else begin
            // shift-out side
            if (so_prev_f && !fifo_so && q.size() > 0) void'(q.pop_front());
            or_prev = or_r;
            if (fifo_so) or_r = 0;
            else if (!or_r && q.size() > 0) or_r = 1;
            if (or_r) f_dout = q[0];
            // shift-in side: IR holds its value while SI is high
            ir_prev = ir_r;
            if (si_r) begin
                si_r = 0;
                ir_r = (q.size() < DEP);
            end else if (sent < to_send && (&f_ir) &&
                         (phase != 2 || (cyc % 200) < 140)) begin
                w = 8'($urandom);
                q.push_back(w);
                exp_q.push_back(w);
                sent++;
                si_r = 1;
            end else begin
                ir_r = (q.size() < DEP);
            end
            f_si   = si_r;
            f_or   = {or_r && or_prev, or_r};
            f_ir   = {ir_r && ir_prev, ir_r};
            f_fill = LW'(q.size());
            // consumer request
            unique case (req_mode)
                0: take_req = 1'b1;
                1: take_req = ($urandom_range(0, 3) != 0);
                default: take_req = 1'b0;
            endcase
        end
        so_prev_f = fifo_so;
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", delivered, NWORD + 3);
            finish_run();
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int snap;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(fifo_so == 0, "R1 strobe low in reset", fifo_so, 0);
        chk(word_vld == 0, "R1 valid low in reset", word_vld, 0);
        chk(word == 0, "R1 word cleared in reset", word, 0);
        chk(h_so == 0, "R1 half instance strobe low", h_so, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fifo_so == 0, "R1 strobe low after release", fifo_so, 0);

        // Phase 1: guard timing
        phase = 1; req_mode = 0; to_send = 2;
        wait (delivered == 2);
        repeat (12) @(negedge clk);
        to_send = 3;
        wait (delivered == 3);
        repeat (12) @(negedge clk);
        chk(n_diff == 3, "R5 strobe count in phase 1", n_diff, 3);
        chk(diffs[0] == GUARD, "R5 first word guarded", diffs[0], GUARD);
        chk(diffs[1] == 0, "R6 follow-on word unguarded", diffs[1], 0);
        chk(diffs[2] == GUARD, "R10 guard re-armed after drain", diffs[2], GUARD);

        // Phase 2: random stream with drains and a request hold
        phase = 2; req_mode = 1; to_send = 3 + NWORD;
        wait (delivered >= 100);
        req_mode = 2;
        @(negedge clk);
        @(negedge clk);
        snap = delivered;
        repeat (30) @(negedge clk);
        chk(delivered == snap, "R7 no delivery while request low", delivered, snap);
        req_mode = 1;
        wait (delivered == 3 + NWORD);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);
        chk(delivered == 3 + NWORD, "R4 delivered count", delivered, 3 + NWORD);

        // Phase 3: half-full start gate
        phase = 3;
        h_or = 1'b1; h_req = 1'b1; h_fill = LW'(DEP / 2);
        repeat (6) begin
            @(negedge clk);
            chk(h_so == 0, "R8 strobe held at half fill", h_so, 0);
        end
        h_fill = LW'(DEP / 2 + 1);
        @(negedge clk);
        chk(h_so == 1, "R8 strobe once above half", h_so, 1);
        chk(h_vld == 1, "R8 valid with strobe", h_vld, 1);
        chk(h_word == 4'hA, "R8 captured word", h_word, 4'hA);
        @(negedge clk);
        chk(h_so == 1, "R3 strobe held while ready high", h_so, 1);
        chk(h_vld == 0, "R4 valid lasts one cycle", h_vld, 0);
        h_or = 1'b0;
        @(negedge clk);
        chk(h_so == 0, "R3 strobe released after ready low", h_so, 0);

        finish_run();
    end

endmodule